// File: doc/BRIEF.md
# Copy Request Descriptor Splitter

This block takes a memory-to-memory copy request (source address, destination address, byte length) and cuts it into chunks no longer than a fixed per-descriptor limit, 0x3F80 bytes by default. Each chunk goes out on a descriptor write port as one source/destination pair, with its slot index in a circular descriptor ring. The last chunk of every request is tagged, so the completion side can report per request rather than per chunk.

A counter tracks how many ring slots are free. One slot is always held back, so a ring of N entries offers N-1 usable slots. When the counter reaches zero the splitter stalls mid-request and keeps the remaining address and length. It resumes as soon as the completion side returns slots through a one-slot-per-cycle release input. The producer index seen by the consuming engine changes only once the writes of a batch have finished. A new request is taken only after the previous one has been fully issued.

Top module: `copy_splitter`

## Requirements
- R1: Each chunk length is the smaller of the remaining length and MAX_CHUNK (default 0x3F80), never zero. A request of length L yields ceil(L / MAX_CHUNK) chunks.
- R2: The first chunk carries the request's source and destination addresses. Each later chunk's addresses are the previous chunk's addresses plus the previous chunk length.
- R3: `desc_last_o` is 1 on the final chunk of a request and 0 on every other chunk.
- R4: After reset `free_slots_o` is RING_DEPTH-1. Every descriptor write uses one slot. No write happens while `free_slots_o` is 0: the splitter stalls and later resumes the same request where it stopped.
- R5: A `release_i` pulse adds one free slot, but the count never rises above RING_DEPTH-1. A release in the same cycle as a write leaves the count unchanged.
- R6: `desc_idx_o` starts at 0 and advances by one, modulo RING_DEPTH, after each write.
- R7: `prod_idx_o` holds its value through a run of consecutive writes. It takes the next-write index in the second cycle after the last write of the run.
- R8: `req_ready_o` is 1 only when no request is in progress. It drops after acceptance and returns in the cycle after the last chunk is written. A request offered while it is 0 is neither taken nor allowed to disturb the one in progress.
- R9: A zero-length request is accepted and produces no descriptor write.
- R10: After reset, `req_ready_o` is 1, `desc_we_o` is 0 and `prod_idx_o` is 0.
- R11: With free slots available, the first chunk is written in the cycle right after the request is accepted, and one chunk is written per cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Copy request offered |
| req_ready_o | output | 1 | Splitter idle, request taken on valid and ready |
| req_src_i | input | ADDR_W | Request source address |
| req_dst_i | input | ADDR_W | Request destination address |
| req_len_i | input | LEN_W | Request length in bytes |
| release_i | input | 1 | Completion side returns one ring slot |
| desc_we_o | output | 1 | Descriptor pair write strobe |
| desc_idx_o | output | IDX_W | Ring slot being written |
| desc_src_o | output | ADDR_W | Chunk source address |
| desc_dst_o | output | ADDR_W | Chunk destination address |
| desc_len_o | output | CHUNK_W | Chunk length |
| desc_last_o | output | 1 | Chunk ends its request |
| prod_idx_o | output | IDX_W | Producer index published to the engine |
| free_slots_o | output | IDX_W | Free ring slot count |

## Verification
A slot release and a descriptor write can land in the same cycle, and the free count must then hold steady instead of moving twice. The bench forces this two ways. In the first, it fills the ring until the splitter stalls, then returns slots one per cycle, so each returned slot is used in the next cycle while the next release arrives. In the second, it holds the release input high through a whole multi-chunk request that starts with a full count. In both cases the free count is compared with a model that adds releases and subtracts writes, and the resumed chunks are checked for contiguous addresses and a correct final tag.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } split_state_e;
endpackage

// File: rtl/cs_slot_counter.sv
module cs_slot_counter #(
  parameter int RING_DEPTH = 16,
  parameter int CNT_W      = $clog2(RING_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             give_i,
  output logic [CNT_W-1:0] free_o,
  output logic             avail_o
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(RING_DEPTH - 1);

  logic [CNT_W-1:0] free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= CAP;
    end else if (take_i && !give_i) begin
      free_q <= free_q - 1'b1;
    end else if (!take_i && give_i && free_q != CAP) begin
      free_q <= free_q + 1'b1;
    end
  end

  assign free_o  = free_q;
  assign avail_o = (free_q != '0);
endmodule

// File: rtl/cs_chunk_engine.sv
module cs_chunk_engine
  import cs_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 20,
  parameter int MAX_CHUNK = 16256,
  parameter int CHUNK_W   = $clog2(MAX_CHUNK + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_src_i,
  input  logic [ADDR_W-1:0]  req_dst_i,
  input  logic [LEN_W-1:0]   req_len_i,
  input  logic               slot_avail_i,
  output logic               req_ready_o,
  output logic               issue_o,
  output logic [ADDR_W-1:0]  src_o,
  output logic [ADDR_W-1:0]  dst_o,
  output logic [CHUNK_W-1:0] len_o,
  output logic               last_o
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_CHUNK);

  split_state_e      state_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  rem_q;
  logic [LEN_W-1:0]  chunk;
  logic              fits;
  logic              accept;

  assign fits        = (rem_q <= MAX_L);
  assign chunk       = fits ? rem_q : MAX_L;
  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign issue_o     = (state_q == ST_ISSUE) && slot_avail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
    end else if (accept) begin
      src_q <= req_src_i;
      dst_q <= req_dst_i;
      rem_q <= req_len_i;
      // zero-length requests are swallowed
      if (req_len_i != '0) state_q <= ST_ISSUE;
    end else if (issue_o) begin
      src_q <= src_q + ADDR_W'(chunk);
      dst_q <= dst_q + ADDR_W'(chunk);
      rem_q <= rem_q - chunk;
      if (fits) state_q <= ST_IDLE;
    end
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign len_o  = chunk[CHUNK_W-1:0];
  assign last_o = fits;
endmodule

// File: rtl/cs_publisher.sv
module cs_publisher #(
  parameter int RING_DEPTH = 16,
  parameter int IDX_W      = $clog2(RING_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             write_i,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [IDX_W-1:0] prod_idx_o
);
  logic [IDX_W-1:0] wr_q, prod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      prod_q <= '0;
    end else begin
      if (write_i) wr_q <= wr_q + 1'b1;
      // publish only once the batch has stopped writing
      else         prod_q <= wr_q;
    end
  end

  assign wr_idx_o   = wr_q;
  assign prod_idx_o = prod_q;
endmodule

// File: rtl/copy_splitter.sv
module copy_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 20,
  parameter int MAX_CHUNK  = 16256,
  parameter int RING_DEPTH = 16,
  localparam int CHUNK_W   = $clog2(MAX_CHUNK + 1),
  localparam int IDX_W     = $clog2(RING_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_src_i,
  input  logic [ADDR_W-1:0]  req_dst_i,
  input  logic [LEN_W-1:0]   req_len_i,
  input  logic               release_i,
  output logic               desc_we_o,
  output logic [IDX_W-1:0]   desc_idx_o,
  output logic [ADDR_W-1:0]  desc_src_o,
  output logic [ADDR_W-1:0]  desc_dst_o,
  output logic [CHUNK_W-1:0] desc_len_o,
  output logic               desc_last_o,
  output logic [IDX_W-1:0]   prod_idx_o,
  output logic [IDX_W-1:0]   free_slots_o
);
  logic slot_avail;

  cs_slot_counter #(.RING_DEPTH(RING_DEPTH), .CNT_W(IDX_W)) u_slots (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (desc_we_o),
    .give_i  (release_i),
    .free_o  (free_slots_o),
    .avail_o (slot_avail)
  );

  cs_chunk_engine #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK), .CHUNK_W(CHUNK_W)
  ) u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_src_i    (req_src_i),
    .req_dst_i    (req_dst_i),
    .req_len_i    (req_len_i),
    .slot_avail_i (slot_avail),
    .req_ready_o  (req_ready_o),
    .issue_o      (desc_we_o),
    .src_o        (desc_src_o),
    .dst_o        (desc_dst_o),
    .len_o        (desc_len_o),
    .last_o       (desc_last_o)
  );

  cs_publisher #(.RING_DEPTH(RING_DEPTH), .IDX_W(IDX_W)) u_pub (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .write_i    (desc_we_o),
    .wr_idx_o   (desc_idx_o),
    .prod_idx_o (prod_idx_o)
  );
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 20,
  parameter int MAX_CHUNK  = 16256,
  parameter int RING_DEPTH = 16,
  parameter int CHUNK_W    = $clog2(MAX_CHUNK + 1),
  parameter int IDX_W      = $clog2(RING_DEPTH)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [LEN_W-1:0]   req_len_i,
  input logic               release_i,
  input logic               desc_we_o,
  input logic [IDX_W-1:0]   desc_idx_o,
  input logic [ADDR_W-1:0]  desc_src_o,
  input logic [ADDR_W-1:0]  desc_dst_o,
  input logic [CHUNK_W-1:0] desc_len_o,
  input logic               desc_last_o,
  input logic [IDX_W-1:0]   prod_idx_o,
  input logic [IDX_W-1:0]   free_slots_o
);
  localparam logic [IDX_W-1:0]   CAP   = IDX_W'(RING_DEPTH - 1);
  localparam logic [CHUNK_W-1:0] MAX_C = CHUNK_W'(MAX_CHUNK);

  // R1
  chunk_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_we_o |-> (desc_len_o != '0 && desc_len_o <= MAX_C));
  // R1
  full_chunk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_we_o && !desc_last_o) |-> desc_len_o == MAX_C);
  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_we_o && !desc_last_o) |=>
      (!desc_we_o || (desc_src_o == $past(desc_src_o) + ADDR_W'($past(desc_len_o)) &&
                      desc_dst_o == $past(desc_dst_o) + ADDR_W'($past(desc_len_o)))));
  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_we_o |-> free_slots_o != '0);
  // R5
  cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_slots_o <= CAP);
  // R5
  give_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i && !desc_we_o && free_slots_o != CAP) |=> free_slots_o == $past(free_slots_o) + 1'b1);
  // R5
  both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i && desc_we_o) |=> $stable(free_slots_o));
  // R4
  take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!release_i && desc_we_o) |=> free_slots_o == $past(free_slots_o) - 1'b1);
  // R6
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_we_o |=> desc_idx_o == $past(desc_idx_o) + 1'b1);
  // R7
  prod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_we_o |=> $stable(prod_idx_o));
  // R8
  ready_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_we_o && desc_last_o) |=> req_ready_o);
  // R8
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_we_o && !desc_last_o) |=> !req_ready_o);
  // R8
  no_write_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !desc_we_o);
  // R11
  first_chunk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_len_i != '0 && free_slots_o != '0) |=> desc_we_o);
endmodule

bind copy_splitter cs_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK), .RING_DEPTH(RING_DEPTH),
  .CHUNK_W(CHUNK_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_len_i    (req_len_i),
  .release_i    (release_i),
  .desc_we_o    (desc_we_o),
  .desc_idx_o   (desc_idx_o),
  .desc_src_o   (desc_src_o),
  .desc_dst_o   (desc_dst_o),
  .desc_len_o   (desc_len_o),
  .desc_last_o  (desc_last_o),
  .prod_idx_o   (prod_idx_o),
  .free_slots_o (free_slots_o)
);

// File: tb/copy_splitter_test.sv
`timescale 1ns/1ps
module copy_splitter_test;
  localparam int MAX   = 16256;
  localparam int DEPTH = 16;
  localparam int NV    = 5;
  localparam logic [31:0] V_SRC [NV] = '{32'h0000_1000, 32'h0000_0000, 32'h0000_0040, 32'h0000_0100, 32'hFFFF_FF00};
  localparam logic [31:0] V_DST [NV] = '{32'h0000_8000, 32'h0010_0000, 32'h0000_2040, 32'h0009_0000, 32'h0000_0010};
  localparam logic [19:0] V_LEN [NV] = '{20'd4, 20'd16256, 20'd16257, 20'd48773, 20'd100};
  localparam int          V_NCH [NV] = '{1, 1, 2, 4, 1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_src = '0, req_dst = '0;
  logic [19:0] req_len = '0;
  logic        rel = 1'b0;
  logic        we;
  logic [3:0]  idx, prod, free;
  logic [31:0] d_src, d_dst;
  logic [13:0] d_len;
  logic        d_last;

  int n_chk = 0, n_fail = 0;
  logic [31:0] cur_src, cur_dst;
  logic [19:0] cur_rem;
  logic [3:0]  exp_idx = '0;

  always #2.5 clk = ~clk;

  copy_splitter uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_src_i(req_src), .req_dst_i(req_dst), .req_len_i(req_len), .release_i(rel),
    .desc_we_o(we), .desc_idx_o(idx), .desc_src_o(d_src), .desc_dst_o(d_dst),
    .desc_len_o(d_len), .desc_last_o(d_last), .prod_idx_o(prod), .free_slots_o(free)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] s, input logic [31:0] d, input logic [19:0] l);
    @(posedge clk); #1;
    req_valid = 1'b1; req_src = s; req_dst = d; req_len = l;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    cur_src = s; cur_dst = d; cur_rem = l;
  endtask

  // gathers up to max_n chunks; returns at the negedge of the last one
  task automatic collect(input int max_n, output int nch, output int first_wait);
    int waited = 0;
    bit first = 1'b1, prev_we = 1'b0;
    logic [3:0] run_prod = '0;
    logic [19:0] el;
    nch = 0; first_wait = -1;
    while (cur_rem != 0 && nch < max_n && waited < 200) begin
      if (!first) @(posedge clk);
      first = 1'b0;
      @(negedge clk);
      if (we) begin
        el = (cur_rem > 20'(MAX)) ? 20'(MAX) : cur_rem;
        if (first_wait < 0) first_wait = waited;
        if (!prev_we) run_prod = prod;
        chk(prod == run_prod, "R7 prod held in run", 64'(prod), 64'(run_prod));
        chk(idx == exp_idx, "R6 slot index", 64'(idx), 64'(exp_idx));
        chk(d_src == cur_src, "R2 src", 64'(d_src), 64'(cur_src));
        chk(d_dst == cur_dst, "R2 dst", 64'(d_dst), 64'(cur_dst));
        chk(20'(d_len) == el, "R1 chunk len", 64'(d_len), 64'(el));
        chk(d_last == (cur_rem <= 20'(MAX)), "R3 last flag", 64'(d_last), 64'(cur_rem <= 20'(MAX)));
        cur_src += 32'(el); cur_dst += 32'(el); cur_rem -= el;
        exp_idx = exp_idx + 1'b1;
        nch++;
      end else waited++;
      prev_we = we;
    end
  endtask

  task automatic release_n(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1; rel = 1'b1;
    end
    @(posedge clk); #1; rel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int nch, fw;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10 ready", 64'(req_ready), 1);
    chk(we == 1'b0, "R10 we", 64'(we), 0);
    chk(prod == 4'd0, "R10 prod", 64'(prod), 0);
    chk(free == 4'(DEPTH - 1), "R4 reset free", 64'(free), DEPTH - 1);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      send(V_SRC[v], V_DST[v], V_LEN[v]);
      collect(100, nch, fw);
      chk(nch == V_NCH[v], "R1 chunk count", 64'(nch), 64'(V_NCH[v]));
      chk(fw == 0, "R11 first chunk latency", 64'(fw), 0);
      release_n(nch);
      @(negedge clk);
      chk(free == 4'(DEPTH - 1), "R5 free restored", 64'(free), DEPTH - 1);
      chk(prod == exp_idx, "R7 prod published", 64'(prod), 64'(exp_idx));
    end

    // R9 zero length
    send(32'h500, 32'h600, 20'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(we == 1'b0, "R9 no write on zero length", 64'(we), 0);
      chk(req_ready == 1'b1, "R9 ready after zero length", 64'(req_ready), 1);
      @(posedge clk);
    end

    // R4 stall on full ring, resume under concurrent release
    send(32'h0001_0000, 32'h0200_0000, 20'(20 * MAX));
    collect(DEPTH - 1, nch, fw);
    chk(nch == DEPTH - 1, "R4 usable slots", 64'(nch), DEPTH - 1);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      chk(we == 1'b0, "R4 stalled", 64'(we), 0);
      chk(free == 4'd0, "R4 free zero", 64'(free), 0);
      chk(req_ready == 1'b0, "R8 busy while stalled", 64'(req_ready), 0);
    end
    chk(prod == exp_idx, "R7 prod after batch", 64'(prod), 64'(exp_idx));
    fork
      release_n(5);
      collect(5, nch, fw);
    join
    chk(nch == 5, "R4 resumed chunks", 64'(nch), 5);
    chk(cur_rem == 20'd0, "R4 request finished", 64'(cur_rem), 0);
    @(negedge clk);
    chk(free == 4'd0, "R5 concurrent release and write", 64'(free), 0);
    chk(req_ready == 1'b1, "R8 ready after last", 64'(req_ready), 1);
    release_n(DEPTH - 1);
    @(negedge clk);
    chk(free == 4'(DEPTH - 1), "R5 refill", 64'(free), DEPTH - 1);
    release_n(2);
    @(negedge clk);
    chk(free == 4'(DEPTH - 1), "R5 saturate", 64'(free), DEPTH - 1);

    // R5 release held through issue at full count
    @(posedge clk); #1; rel = 1'b1;
    send(32'h0300_0000, 32'h0400_0000, 20'(2 * MAX + 7));
    collect(100, nch, fw);
    chk(nch == 3, "R1 three chunks", 64'(nch), 3);
    @(negedge clk);
    chk(free == 4'(DEPTH - 1), "R5 release cancels write", 64'(free), DEPTH - 1);
    @(posedge clk); #1; rel = 1'b0;

    // R8 request offered while busy waits its turn
    send(32'h0000_A000, 32'h0000_B000, 20'(MAX + 3));
    req_valid = 1'b1; req_src = 32'h0000_C000; req_dst = 32'h0000_D000; req_len = 20'd8;
    @(negedge clk);
    chk(req_ready == 1'b0, "R8 not ready while busy", 64'(req_ready), 0);
    @(posedge clk); @(negedge clk);
    chk(we && d_last && d_src == 32'h0000_A000 + 32'(MAX), "R8 busy request undisturbed",
        64'(d_src), 64'(32'h0000_A000 + 32'(MAX)));
    exp_idx = exp_idx + 2'd2;
    @(posedge clk); @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready returns", 64'(req_ready), 1);
    @(posedge clk); #1; req_valid = 1'b0;
    cur_src = 32'h0000_C000; cur_dst = 32'h0000_D000; cur_rem = 20'd8;
    collect(100, nch, fw);
    chk(nch == 1 && fw == 0, "R11 queued request issued", 64'(nch), 1);

    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule